// File: doc/BRIEF.md
# Edge-Masked Block-Boundary Offset Filter

This block smooths the step that block-based compression leaves between two neighbouring 8-pixel blocks. Each enabled clock it receives one line of eight 8-bit pixels and a matching vector of per-pixel edge flags. The line crosses the block seam between its fourth and fifth pixel. The block measures the jump across the seam and spreads a correction over the line. The correction is halved for each step away from the seam and acts in opposite directions on the two sides.

Pixels flagged as lying on an edge keep their value, so detail is not blurred. The two pixels next to the seam are the exception: they always receive a correction, and a flagged seam pixel gets a smaller one. The result is registered, so an 8×8 block needs eight consecutive vectors. One instance handles rows using horizontal edge flags. A second instance handles columns using vertical edge flags.

Top module: `boundary_offset_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `vec_out` to all zeros and `vec_valid` to 0.
- R2: `vec_valid` is 1 in the cycle after an edge at which `vec_in_valid` and `pass_en` were both 1, and 0 otherwise.
- R3: `vec_out` keeps its value through any edge at which `vec_in_valid` or `pass_en` is 0.
- R4: Pixel k (k = 1..8) is carried in bits [8k-1:8k-8] of `vec_in` and `vec_out`, and its edge flag is bit k-1 of `edge_in` (1 means edge). The step is the signed 9-bit value pixel4 − pixel5. Every fraction of the step is an arithmetic right shift, so it rounds toward minus infinity.
- R5: Pixels 1, 2 and 3 have step>>>4, step>>>3 and step>>>2 subtracted when their flag is 0. They pass through unchanged when their flag is 1.
- R6: Pixels 6, 7 and 8 have step>>>2, step>>>3 and step>>>4 added when their flag is 0. They pass through unchanged when their flag is 1.
- R7: Pixel 4 has step>>>1 subtracted when its flag is 0 and step>>>2 subtracted when its flag is 1. Pixel 5 has the same amounts added under the same rule.
- R8: Every corrected result is clamped to the range 0..255.
- R9: Results appear one cycle after capture, and a new vector is accepted on every enabled cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pass_en | input | 1 | Pass enable; gates capture of a vector |
| vec_in_valid | input | 1 | A vector is present on `vec_in` |
| vec_in | input | 64 | Eight pixels, pixel 1 in the low byte |
| edge_in | input | 8 | Edge flag per pixel, bit 0 for pixel 1 |
| vec_out | output | 64 | Corrected pixels, same packing |
| vec_valid | output | 1 | `vec_out` holds a newly captured result |

## Verification
The only state is the output register and the valid flag, so a fault shows up as a wrong byte or a wrong valid on the cycle right after the capture that caused it. A fault that leaves a stale value in place can instead show as an output that changes when it should hold. The bench predicts every vector byte for byte. It covers steps of both signs, each edge-flag mix, clamping at both rails and enable gaps, so a wrong shift, side or flag rule shows in the faulty lane at once.

// File: rtl/bof_pkg.sv
// Package: shared types for the boundary offset filter.
// Assumes: nothing; pure declarations.
package bof_pkg;
    // Which side of the block seam a lane lies on; selects subtract or add.
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } seam_side_e;

    // Shift applied to a seam pixel that is flagged as an edge.
    localparam int SEAM_EDGE_SHIFT = 2;
endpackage

// File: rtl/bof_step.sv
// Module: bof_step
// Computes the signed jump across the seam from the two pixels beside it.
// Assumes: unsigned pixels of PIX_W bits; the result is one bit wider and signed.
module bof_step #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0]      near_left,
    input  logic [PIX_W-1:0]      near_right,
    output logic signed [PIX_W:0] step
);
    // Zero-extend both pixels and subtract them as signed values.
    always_comb begin
        step = $signed({1'b0, near_left}) - $signed({1'b0, near_right});
    end
endmodule

// File: rtl/bof_lane.sv
// Module: bof_lane
// Corrects one pixel by a shifted fraction of the seam step, gated by its edge flag.
// Assumes: DIST counts lanes away from the seam (0 = seam neighbour); the smooth
// shift is DIST+1; edge-flagged lanes are left alone unless DIST is 0.
module bof_lane
    import bof_pkg::*;
#(
    parameter int         PIX_W = 8,
    parameter int         DIST  = 0,
    parameter seam_side_e SIDE  = SIDE_LEFT
) (
    input  logic [PIX_W-1:0]      pix,
    input  logic                  edge_flag,
    input  logic signed [PIX_W:0] step,
    output logic [PIX_W-1:0]      corr
);
    localparam int SMOOTH_SH = DIST + 1;
    localparam bit IS_SEAM   = (DIST == 0);
    localparam int SUM_W     = PIX_W + 2;
    localparam int PIX_MAX   = (1 << PIX_W) - 1;

    logic signed [PIX_W:0]   frac;
    logic signed [SUM_W-1:0] pix_ext;
    logic signed [SUM_W-1:0] frac_ext;
    logic signed [SUM_W-1:0] sum;

    // Pick the fraction: smooth shift, seam fallback shift, or nothing.
    always_comb begin
        if (!edge_flag)
            frac = step >>> SMOOTH_SH;
        else if (IS_SEAM)
            frac = step >>> SEAM_EDGE_SHIFT;
        else
            frac = '0;
        pix_ext  = $signed({2'b00, pix});
        frac_ext = SUM_W'(frac);
    end

    // Apply the fraction with the sign chosen by the side of the seam.
    generate
        if (SIDE == SIDE_LEFT) begin : g_left
            always_comb sum = pix_ext - frac_ext;
        end else begin : g_right
            always_comb sum = pix_ext + frac_ext;
        end
    endgenerate

    // Clamp the result to the pixel range.
    always_comb begin
        if (sum < 0)
            corr = '0;
        else if (sum > SUM_W'(PIX_MAX))
            corr = PIX_W'(PIX_MAX);
        else
            corr = sum[PIX_W-1:0];
    end
endmodule

// File: rtl/boundary_offset_filter.sv
// Module: boundary_offset_filter
// Top: one line of LANES pixels crossing a block seam in its middle is corrected
// per enabled clock, and the result is registered.
// Assumes: LANES is even; the seam lies between lanes LANES/2-1 and LANES/2
// (zero-based). Lane 0 sits in the low bits of the vectors.
module boundary_offset_filter
    import bof_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int LANES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pass_en,
    input  logic                     vec_in_valid,
    input  logic [LANES*PIX_W-1:0]   vec_in,
    input  logic [LANES-1:0]         edge_in,
    output logic [LANES*PIX_W-1:0]   vec_out,
    output logic                     vec_valid
);
    localparam int HALF  = LANES / 2;
    localparam int VEC_W = LANES * PIX_W;

    logic signed [PIX_W:0] seam_step;
    logic [VEC_W-1:0]      corr_vec;
    logic                  capture;

    assign capture = vec_in_valid & pass_en;

    // Jump across the seam from the two lanes beside it.
    bof_step #(.PIX_W(PIX_W)) u_step (
        .near_left  (vec_in[(HALF-1)*PIX_W +: PIX_W]),
        .near_right (vec_in[HALF*PIX_W +: PIX_W]),
        .step       (seam_step)
    );

    // One correction lane per pixel; distance and side follow from the position.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            if (i < HALF) begin : g_l
                bof_lane #(.PIX_W(PIX_W), .DIST(HALF-1-i), .SIDE(SIDE_LEFT)) u_lane (
                    .pix       (vec_in[i*PIX_W +: PIX_W]),
                    .edge_flag (edge_in[i]),
                    .step      (seam_step),
                    .corr      (corr_vec[i*PIX_W +: PIX_W])
                );
            end else begin : g_r
                bof_lane #(.PIX_W(PIX_W), .DIST(i-HALF), .SIDE(SIDE_RIGHT)) u_lane (
                    .pix       (vec_in[i*PIX_W +: PIX_W]),
                    .edge_flag (edge_in[i]),
                    .step      (seam_step),
                    .corr      (corr_vec[i*PIX_W +: PIX_W])
                );
            end
        end
    endgenerate

    // Output register: load on capture, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= capture;
            if (capture)
                vec_out <= corr_vec;
        end
    end

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> vec_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> !vec_valid);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(vec_out));
    // R7
    seam_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && seam_step >= 0) |=>
            (vec_out[(HALF-1)*PIX_W +: PIX_W] <= $past(vec_in[(HALF-1)*PIX_W +: PIX_W]))
         && (vec_out[HALF*PIX_W +: PIX_W] >= $past(vec_in[HALF*PIX_W +: PIX_W])));

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_edge_chk
            if (k != HALF-1 && k != HALF) begin : g_outer
                // R5 R6
                edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (capture && edge_in[k]) |=>
                        vec_out[k*PIX_W +: PIX_W] == $past(vec_in[k*PIX_W +: PIX_W]));
            end
        end
    endgenerate
endmodule

// File: tb/sim_boundary_offset_filter.sv
module sim_boundary_offset_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pass_en;
    logic        vec_in_valid;
    logic [63:0] vec_in;
    logic [7:0]  edge_in;
    logic [63:0] vec_out;
    logic        vec_valid;

    int checks   = 0;
    int failures = 0;
    logic [63:0] exp_pix   = '0;
    logic        exp_valid = 1'b0;

    always #5 clk = ~clk;

    boundary_offset_filter u0 (
        .clk(clk), .rst_n(rst_n), .pass_en(pass_en), .vec_in_valid(vec_in_valid),
        .vec_in(vec_in), .edge_in(edge_in), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    // Reference from the requirements: per-pixel shift table, floor shifts, clamp.
    function automatic logic [63:0] ref_vec(logic [63:0] v, logic [7:0] e);
        int p [8];
        int off;
        logic [63:0] o;
        for (int i = 0; i < 8; i++) p[i] = int'(v[i*8 +: 8]);
        off = p[3] - p[4];
        for (int i = 0; i < 8; i++) begin
            int s;
            int amt;
            int r;
            case (i)
                0, 7:    s = 4;
                1, 6:    s = 3;
                2, 5:    s = 2;
                default: s = 1;
            endcase
            if (e[i]) s = (i == 3 || i == 4) ? 2 : -1;
            amt = (s < 0) ? 0 : (off >>> s);
            r = (i < 4) ? p[i] - amt : p[i] + amt;
            if (r < 0) r = 0;
            if (r > 255) r = 255;
            o[i*8 +: 8] = r[7:0];
        end
        return o;
    endfunction

    function automatic logic [63:0] pack(int a, int b, int c, int d, int e, int f, int g, int h);
        return {h[7:0], g[7:0], f[7:0], e[7:0], d[7:0], c[7:0], b[7:0], a[7:0]};
    endfunction

    // Compare outputs against the model, then drive the next stimulus.
    task automatic cycle(input logic v, input logic en, input logic [63:0] pix,
                         input logic [7:0] fl, input string tag);
        @(negedge clk);
        checks++;
        if (vec_out !== exp_pix) begin
            failures++;
            $display("FAIL %s vec_out act=%h exp=%h", tag, vec_out, exp_pix);
        end
        checks++;
        if (vec_valid !== exp_valid) begin
            failures++;
            $display("FAIL %s vec_valid act=%b exp=%b", tag, vec_valid, exp_valid);
        end
        vec_in_valid = v;
        pass_en      = en;
        vec_in       = pix;
        edge_in      = fl;
        exp_valid    = v & en;
        if (v & en) exp_pix = ref_vec(pix, fl);
    endtask

    initial begin
        int n = 0;
        while (n < 100000) begin
            @(posedge clk);
            n++;
        end
        failures++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pass_en = 1'b1; vec_in_valid = 1'b1;
        vec_in = pack(1,2,3,4,5,6,7,8); edge_in = 8'h00;
        repeat (3) @(posedge clk);
        // R1: reset clears the outputs even with a valid input present
        @(negedge clk);
        checks++;
        if (vec_out !== '0 || vec_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 act=%h/%b exp=0/0", vec_out, vec_valid);
        end
        rst_n = 1'b1; vec_in_valid = 1'b0;
        exp_pix = '0; exp_valid = 1'b0;

        cycle(1, 1, pack(100,100,100,100,60,60,60,60), 8'h00, "R4 R5 R6 R7 smooth");
        cycle(1, 1, pack(100,100,100,100,60,60,60,60), 8'he7, "R5 R6 edge keep");
        cycle(1, 1, pack(100,100,100,100,60,60,60,60), 8'h18, "R7 seam fallback");
        cycle(1, 1, pack(30,30,30,0,255,220,220,220), 8'h00, "R4 R8 negative step");
        cycle(1, 1, pack(5,5,5,255,0,250,250,250), 8'h00, "R8 clamp");
        cycle(1, 1, pack(90,91,92,93,90,89,88,87), 8'h00, "R4 odd step floor");
        cycle(1, 1, pack(90,91,92,90,93,89,88,87), 8'h08, "R4 R7 negative odd step");
        cycle(1, 0, pack(0,0,0,200,10,0,0,0), 8'h00, "R3 enable low");
        cycle(0, 1, pack(0,0,0,10,200,0,0,0), 8'h00, "R3 R2 no valid");
        cycle(0, 0, pack(9,9,9,9,9,9,9,9), 8'hff, "R3 idle");
        for (int i = 0; i < 400; i++) begin
            logic [63:0] rv;
            rv = {$urandom, $urandom};
            cycle((i < 200) ? 1'b1 : 1'($urandom), (i < 200) ? 1'b1 : 1'($urandom),
                  rv, 8'($urandom), "R9 R2 stream");
        end
        cycle(0, 0, '0, '0, "R2 drain");
        cycle(0, 0, '0, '0, "R3 drain hold");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule